// File: doc/BRIEF.md
# Dirty Band Update Coalescer

This block walks a framebuffer's per-page dirty bitmap and turns it into a short list of screen refresh rectangles. Each page covers a band of four display lines. The block reads one page index at a time and gets back one dirty bit per memory plane one cycle later. A band is dirty when any of those plane bits is set. Adjacent dirty bands merge into one update record. Each record gives a starting line and a line count, and every record spans the full width of the screen.

During the scan the block also keeps the lowest and the highest dirty page it has seen. After the last band it issues one clear request for that inclusive page range, so the bitmap owner can reset the marks. If no band was dirty, it issues no clear. A host pulses the start input with the active height. It consumes update records through a valid/ready handshake and clear requests through a second valid/ready handshake, then waits for the done pulse.

The controller is a state machine with seven named states:
- IDLE waits for start.
- READ issues a page read.
- EVAL classifies the returned bits.
- EMIT offers an update record.
- ENDCHK flushes an open run and decides whether a clear is needed.
- CLEAR offers the clear range.
- DONE pulses completion.

Its transitions are:
- IDLE to READ on start with a non-zero height, or IDLE to ENDCHK on start with zero height.
- READ to EVAL, always.
- EVAL to EMIT when a clean band closes a run. Otherwise EVAL goes to READ, or to ENDCHK once the next band would reach the height.
- EMIT to READ or ENDCHK on ready, and EMIT holds while ready is low.
- ENDCHK to EMIT for an open run, to CLEAR when a page was dirty, and to DONE otherwise.
- CLEAR to DONE on ready.
- DONE to IDLE.

Top module: `dirty_band_coalescer`

## Requirements
- R1: After reset the read strobe, update valid, clear valid, busy and done outputs are all low.
- R2: A scan reads pages 0, 1, 2 and so on in rising order, one read per page, ceil(height/4) reads in total. Read data is sampled one cycle after the read strobe.
- R3: A band is dirty when at least one bit of the plane vector returned for its page is 1. The planes are treated alike, so a mark in only one plane is enough.
- R4: A run of consecutive dirty pages p..q that is followed by a clean page produces exactly one update. Its line start is 4*p and its line count is 4*(q-p+1). Updates appear in scan order.
- R5: A run still open at the last page is emitted with a line count measured to line 4*ceil(height/4). This count may pass the height.
- R6: An update whose valid is high and whose ready is low keeps its line start and line count unchanged. No page read is issued while an update is pending.
- R7: When at least one page was dirty, exactly one clear request follows the scan. Its lower bound is the lowest dirty page and its upper bound is the highest dirty page. When no page was dirty, no clear request is made.
- R8: Busy rises in the cycle after start and falls once the clear is accepted, or once the scan ends if no clear is due. Done is a single-cycle pulse that comes after busy falls. A clear request holds its bounds until ready.
- R9: A start pulse while busy has no effect. The scan in progress keeps its latched height and page sequence.
- R10: A height of zero gives no reads, no updates and no clear, only a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a scan; ignored while busy |
| height_i | input | LINE_W | Active height in lines, latched at start |
| rd_en_o | output | 1 | Page read strobe |
| rd_page_o | output | LINE_W-2 | Page index being read |
| rd_dirty_i | input | NPLANES | Per-plane dirty bits, valid one cycle after the strobe |
| upd_valid_o | output | 1 | Update record offered |
| upd_ready_i | input | 1 | Update record accepted |
| upd_y_o | output | LINE_W | First line of the update |
| upd_lines_o | output | LINE_W+1 | Number of lines in the update |
| clr_valid_o | output | 1 | Clear request offered |
| clr_ready_i | input | 1 | Clear request accepted |
| clr_min_o | output | LINE_W-2 | Lowest dirty page, inclusive |
| clr_max_o | output | LINE_W-2 | Highest dirty page, inclusive |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume three things about the environment:
- The bitmap port answers every read strobe with data in the very next cycle.
- The height input is meaningful only when start is sampled.
- The two ready inputs may drop at any time but are never required to rise.

The bench keeps to these assumptions in the following ways:
- It models the bitmap as registered arrays that answer each read one cycle later.
- It stalls both ready lines on fixed cycle patterns, so that holds are seen on updates and on clears.
- It changes the height only together with a start pulse. In one case that start pulse is sent mid-scan on purpose.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
    localparam int BAND_SHIFT = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_EMIT,
        ST_ENDCHK,
        ST_CLEAR,
        ST_DONE
    } scan_state_e;
endpackage

// File: rtl/dbc_plane_merge.sv
module dbc_plane_merge #(
    parameter int NPLANES = 3
) (
    input  logic [NPLANES-1:0] bits_i,
    output logic               any_o
);
    logic [NPLANES:0] acc;
    assign acc[0] = 1'b0;
    for (genvar g = 0; g < NPLANES; g++) begin : g_or
        assign acc[g+1] = acc[g] | bits_i[g];
    end
    assign any_o = acc[NPLANES];
endmodule

// File: rtl/dbc_extent.sv
module dbc_extent #(
    parameter int PAGE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              hit_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic [PAGE_W-1:0] lo_o,
    output logic [PAGE_W-1:0] hi_o,
    output logic              any_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_o <= '1;
            hi_o <= '0;
        end else if (init_i) begin
            lo_o <= '1;
            hi_o <= '0;
        end else if (hit_i) begin
            if (page_i < lo_o) lo_o <= page_i;
            if (page_i > hi_o) hi_o <= page_i;
        end
    end

    assign any_o = (hi_o >= lo_o);
endmodule

// File: rtl/dirty_band_coalescer.sv
module dirty_band_coalescer
    import dbc_pkg::*;
#(
    parameter int LINE_W  = 12,
    parameter int NPLANES = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [LINE_W-1:0]          height_i,
    output logic                       rd_en_o,
    output logic [LINE_W-BAND_SHIFT-1:0] rd_page_o,
    input  logic [NPLANES-1:0]         rd_dirty_i,
    output logic                       upd_valid_o,
    input  logic                       upd_ready_i,
    output logic [LINE_W-1:0]          upd_y_o,
    output logic [LINE_W:0]            upd_lines_o,
    output logic                       clr_valid_o,
    input  logic                       clr_ready_i,
    output logic [LINE_W-BAND_SHIFT-1:0] clr_min_o,
    output logic [LINE_W-BAND_SHIFT-1:0] clr_max_o,
    output logic                       busy_o,
    output logic                       done_o
);
    localparam int PAGE_W = LINE_W - BAND_SHIFT;
    localparam int YW     = LINE_W + 1;
    localparam logic [YW-1:0] STEP = YW'(1 << BAND_SHIFT);

    scan_state_e state_q, state_d;

    logic [YW-1:0]     y_q;
    logic [LINE_W-1:0] height_q;
    logic [LINE_W-1:0] run_start_q;
    logic              run_open_q;
    logic [LINE_W-1:0] upd_y_q;
    logic [YW-1:0]     upd_lines_q;

    logic              band_dirty;
    logic              ext_any;
    logic [YW-1:0]     y_next;
    logic              next_is_end;
    logic              cur_is_end;
    logic              begin_scan;
    logic              hit;

    assign begin_scan  = (state_q == ST_IDLE) && start_i;
    assign y_next      = y_q + STEP;
    assign next_is_end = (y_next >= {1'b0, height_q});
    assign cur_is_end  = (y_q >= {1'b0, height_q});
    assign hit         = (state_q == ST_EVAL) && band_dirty;

    dbc_plane_merge #(.NPLANES(NPLANES)) u_merge (
        .bits_i (rd_dirty_i),
        .any_o  (band_dirty)
    );

    dbc_extent #(.PAGE_W(PAGE_W)) u_extent (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (begin_scan),
        .hit_i  (hit),
        .page_i (y_q[LINE_W-1:BAND_SHIFT]),
        .lo_o   (clr_min_o),
        .hi_o   (clr_max_o),
        .any_o  (ext_any)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = (height_i == '0) ? ST_ENDCHK : ST_READ;
            ST_READ:   state_d = ST_EVAL;
            ST_EVAL: begin
                if (!band_dirty && run_open_q) state_d = ST_EMIT;
                else state_d = next_is_end ? ST_ENDCHK : ST_READ;
            end
            ST_EMIT:   if (upd_ready_i) state_d = cur_is_end ? ST_ENDCHK : ST_READ;
            ST_ENDCHK: begin
                if (run_open_q)   state_d = ST_EMIT;
                else if (ext_any) state_d = ST_CLEAR;
                else              state_d = ST_DONE;
            end
            ST_CLEAR:  if (clr_ready_i) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // scan datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_q         <= '0;
            height_q    <= '0;
            run_start_q <= '0;
            run_open_q  <= 1'b0;
            upd_y_q     <= '0;
            upd_lines_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    y_q        <= '0;
                    height_q   <= height_i;
                    run_open_q <= 1'b0;
                end
                ST_EVAL: begin
                    y_q <= y_next;
                    if (band_dirty) begin
                        if (!run_open_q) begin
                            run_start_q <= y_q[LINE_W-1:0];
                            run_open_q  <= 1'b1;
                        end
                    end else if (run_open_q) begin
                        upd_y_q     <= run_start_q;
                        upd_lines_q <= y_q - {1'b0, run_start_q};
                        run_open_q  <= 1'b0;
                    end
                end
                ST_ENDCHK: if (run_open_q) begin
                    upd_y_q     <= run_start_q;
                    upd_lines_q <= y_q - {1'b0, run_start_q};
                    run_open_q  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        rd_en_o     = 1'b0;
        upd_valid_o = 1'b0;
        clr_valid_o = 1'b0;
        done_o      = 1'b0;
        busy_o      = 1'b1;
        unique case (state_q)
            ST_IDLE:   busy_o = 1'b0;
            ST_READ:   rd_en_o = 1'b1;
            ST_EVAL:   ;
            ST_EMIT:   upd_valid_o = 1'b1;
            ST_ENDCHK: ;
            ST_CLEAR:  clr_valid_o = 1'b1;
            ST_DONE: begin
                busy_o = 1'b0;
                done_o = 1'b1;
            end
            default:   busy_o = 1'b0;
        endcase
    end

    assign rd_page_o   = y_q[LINE_W-1:BAND_SHIFT];
    assign upd_y_o     = upd_y_q;
    assign upd_lines_o = upd_lines_q;
endmodule

// File: rtl/dbc_checker.sv
module dbc_checker #(
    parameter int LINE_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_en_o,
    input logic                upd_valid_o,
    input logic                upd_ready_i,
    input logic [LINE_W-1:0]   upd_y_o,
    input logic [LINE_W:0]     upd_lines_o,
    input logic                clr_valid_o,
    input logic                clr_ready_i,
    input logic [LINE_W-3:0]   clr_min_o,
    input logic [LINE_W-3:0]   clr_max_o,
    input logic                busy_o,
    input logic                done_o
);
    assert_upd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_o && !upd_ready_i) |=> (upd_valid_o && $stable(upd_y_o) && $stable(upd_lines_o)));

    assert_no_read_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_o |-> !rd_en_o);

    assert_upd_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_o |-> (upd_lines_o[1:0] == 2'b00 && upd_lines_o != '0 && upd_y_o[1:0] == 2'b00));

    assert_clr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid_o && !clr_ready_i) |=> (clr_valid_o && $stable(clr_min_o) && $stable(clr_max_o)));

    assert_clr_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid_o |-> (clr_min_o <= clr_max_o));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_activity_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o || upd_valid_o || clr_valid_o) |-> busy_o);

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_en_o, upd_valid_o, clr_valid_o, done_o}));
endmodule

bind dirty_band_coalescer dbc_checker #(.LINE_W(LINE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en_o     (rd_en_o),
    .upd_valid_o (upd_valid_o),
    .upd_ready_i (upd_ready_i),
    .upd_y_o     (upd_y_o),
    .upd_lines_o (upd_lines_o),
    .clr_valid_o (clr_valid_o),
    .clr_ready_i (clr_ready_i),
    .clr_min_o   (clr_min_o),
    .clr_max_o   (clr_max_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/dirty_band_coalescer_test.sv
module dirty_band_coalescer_test;
    localparam int LW = 12;
    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [LW-1:0] height_i = '0;
    logic          rd_en_o;
    logic [LW-3:0] rd_page_o;
    logic [NP-1:0] rd_dirty_i = '0;
    logic          upd_valid_o;
    logic          upd_ready_i = 1'b1;
    logic [LW-1:0] upd_y_o;
    logic [LW:0]   upd_lines_o;
    logic          clr_valid_o;
    logic          clr_ready_i = 1'b1;
    logic [LW-3:0] clr_min_o, clr_max_o;
    logic          busy_o, done_o;

    always #10 clk = ~clk;

    dirty_band_coalescer #(.LINE_W(LW), .NPLANES(NP)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .height_i(height_i),
        .rd_en_o(rd_en_o), .rd_page_o(rd_page_o), .rd_dirty_i(rd_dirty_i),
        .upd_valid_o(upd_valid_o), .upd_ready_i(upd_ready_i),
        .upd_y_o(upd_y_o), .upd_lines_o(upd_lines_o),
        .clr_valid_o(clr_valid_o), .clr_ready_i(clr_ready_i),
        .clr_min_o(clr_min_o), .clr_max_o(clr_max_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    string tag = "";

    logic [63:0] pl0 = '0, pl1 = '0, pl2 = '0;
    logic stall = 1'b0;
    int cyc = 0;

    typedef struct { int y; int n; } upd_t;
    upd_t exp_q[$];
    int exp_min, exp_max, exp_clears;
    int rd_idx, reads, clears;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", req, tag, act, exp);
        end
    endtask

    // bitmap model: answers one cycle after a read strobe
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_en_o)
            rd_dirty_i <= {pl2[rd_page_o[5:0]], pl1[rd_page_o[5:0]], pl0[rd_page_o[5:0]]};
        upd_ready_i <= !stall || (cyc % 3 == 0);
        clr_ready_i <= !stall || (cyc % 4 == 1);
    end

    // monitor: pops expected updates and compares
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_en_o) begin
                check(rd_page_o == rd_idx[LW-3:0], "R2 page order", int'(rd_page_o), rd_idx);
                rd_idx++;
                reads++;
            end
            if (upd_valid_o && upd_ready_i) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected update", int'(upd_y_o), -1);
                end else begin
                    upd_t e;
                    e = exp_q.pop_front();
                    check(int'(upd_y_o) == e.y, "R4/R3 update start", int'(upd_y_o), e.y);
                    check(int'(upd_lines_o) == e.n, "R4/R5 update lines", int'(upd_lines_o), e.n);
                end
            end
            if (clr_valid_o && clr_ready_i) begin
                clears++;
                check(int'(clr_min_o) == exp_min, "R7 clear min", int'(clr_min_o), exp_min);
                check(int'(clr_max_o) == exp_max, "R7 clear max", int'(clr_max_o), exp_max);
            end
        end
    end

    task automatic run_scan(input int h, input string name, input bit restart);
        int np;
        bit open;
        int st;
        int waited;
        tag = name;
        np = (h + 3) / 4;
        open = 0; st = 0;
        exp_min = -1; exp_max = -1;
        for (int p = 0; p < np; p++) begin
            bit d;
            d = pl0[p] | pl1[p] | pl2[p];
            if (d) begin
                if (!open) begin open = 1; st = 4 * p; end
                if (exp_min < 0) exp_min = p;
                exp_max = p;
            end else if (open) begin
                exp_q.push_back('{st, 4 * p - st});
                open = 0;
            end
        end
        if (open) exp_q.push_back('{st, 4 * np - st});
        exp_clears = (exp_min >= 0) ? 1 : 0;
        rd_idx = 0; reads = 0; clears = 0;
        @(negedge clk);
        start_i = 1'b1; height_i = LW'(h);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R8 busy after start", int'(busy_o), 1);
        if (restart) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1; height_i = LW'(200);
            @(negedge clk);
            start_i = 1'b0;
        end
        waited = 0;
        while (!done_o && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        check(done_o == 1'b1, "R8 done seen", int'(done_o), 1);
        check(busy_o == 1'b0, "R8 busy low at done", int'(busy_o), 0);
        @(negedge clk);
        check(done_o == 1'b0, "R8 done one cycle", int'(done_o), 0);
        check(exp_q.size() == 0, "R4 all updates emitted", exp_q.size(), 0);
        check(reads == np, restart ? "R9 reads with ignored start" : "R2 read count", reads, np);
        check(clears == exp_clears, (h == 0) ? "R10 no clear" : "R7 clear count", clears, exp_clears);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "reset";
        check(rd_en_o == 0 && upd_valid_o == 0 && clr_valid_o == 0, "R1 strobes low", int'(rd_en_o | upd_valid_o | clr_valid_o), 0);
        check(busy_o == 0 && done_o == 0, "R1 busy/done low", int'(busy_o | done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // runs split across planes; page 7 marked only in plane 2 (R3)
        pl0 = 64'h0E; pl1 = 64'h40; pl2 = 64'h80;
        run_scan(40, "two runs R3", 0);
        stall = 1'b1;
        run_scan(40, "two runs stalled R6", 0);
        stall = 1'b0;

        // all dirty, height not a multiple of four (R5)
        pl0 = '1; pl1 = '0; pl2 = '0;
        run_scan(30, "all dirty R5", 0);

        // nothing dirty
        pl0 = '0;
        run_scan(64, "clean R7", 0);

        // zero height
        pl0 = '1;
        run_scan(0, "zero height R10", 0);

        // alternating pages, full bitmap, stalled handshakes
        pl0 = 64'h5555_5555_5555_5555; pl1 = 64'h0; pl2 = 64'h8000_0000_0000_0000;
        stall = 1'b1;
        run_scan(256, "alternating R4", 0);
        stall = 1'b0;

        // start while busy is ignored
        pl0 = 64'h0F0; pl1 = '0; pl2 = '0;
        stall = 1'b1;
        run_scan(40, "restart R9", 1);
        stall = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog [%s] actual=%0d expected=%0d", tag, 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule